// File: doc/BRIEF.md
# Disk Controller Command Phase Sequencer

This block sits between a host CPU and the execution logic of a disk controller, and it takes in commands one byte at a time. The host reads a status byte. Two bits of that byte tell it whether the block will accept a write now: a ready-for-transfer flag and a direction flag. The first byte written is an opcode. The block looks the opcode up in a small table to learn how many parameter bytes must follow. It then asks for those bytes one at a time and stores them in arrival order.

After every accepted byte the ready flag drops. It stays low for a fixed two-cycle processing time. It comes back high only if another parameter byte is wanted. When the last byte has been taken, the ready flag stays low. A one-cycle start pulse then hands the opcode, the parameter count and the collected bytes to the execution logic, and the data FIFO enable is raised. The execution logic signals completion with a done pulse, and the block returns to waiting for a new opcode.

An opcode that is not in the table stops the collection of bytes. The block turns the direction flag around and offers one result byte of 0x80 for the host to read. Once the host reads it, the block is ready for a new command. Writes made while the block is not ready are dropped and latch a sticky overrun flag.

Top module: `cmd_seq_top`

## Requirements
- R1: After synchronous reset, status reads 0x80, and exec_start, fifo_en, overrun and host_rdata are all 0.
- R2: Status bits are [7] ready, [6] direction (1 = block to host), [4] busy, and all other bits are 0. A host write is accepted only when ready=1 and direction=0. After an accepted write, status reads 0x10 for exactly two cycles.
- R3: The opcode table is looked up on opcode bits [4:0] only, and bits [7:5] are ignored for the lookup. The parameter counts are 0x03→2, 0x04→1, 0x05→8, 0x06→8, 0x07→1, 0x08→0, 0x0F→2 and 0x13→3. Every other code is illegal.
- R4: While parameter bytes are still owed, status returns to 0x90 after the processing time of each accepted byte.
- R5: Two cycles after the last byte is accepted, exec_start is high for exactly one cycle and ready stays 0. At that point exec_opcode holds the full 8-bit opcode and exec_count holds the table count. Parameter k sits in exec_params[8k+7:8k], and unused slots read 0.
- R6: fifo_en is 0 in the command and result phases. It is 1 from the exec_start cycle until exec_done is seen.
- R7: exec_done in the execution phase returns status to 0x80 and fifo_en to 0 in the next cycle.
- R8: Two cycles after an illegal opcode, status reads 0xD0 and host_rdata reads 0x80. No exec_start is issued.
- R9: A host read in the result phase returns status to 0x80 and host_rdata to 0x00 in the next cycle.
- R10: A write made while ready=0 or direction=1 is dropped: no byte is stored and no count advances. It also sets overrun, which stays 1 until reset.
- R11: A host read outside the result phase has no effect on status or host_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe for the result byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Result byte, 0x80 in the result phase, else 0 |
| status | output | 8 | Status byte: ready, direction, busy |
| exec_start | output | 1 | One-cycle handoff pulse |
| exec_opcode | output | 8 | Full opcode byte |
| exec_count | output | 4 | Number of parameter bytes |
| exec_params | output | 64 | Parameter bytes, first byte in the low byte |
| exec_done | input | 1 | Completion pulse from the execution logic |
| fifo_en | output | 1 | Data FIFO enable |
| overrun | output | 1 | Sticky flag for dropped writes |

## Verification
Commands are sent with zero, one, two, three and eight parameter bytes. These tell apart a correct count lookup, a count that is off by one, and a handoff that fires too early or too late. Opcodes with the upper three bits set show that the lookup masks those bits while the handoff keeps the full byte. A short command sent after a long one shows that stale parameter slots are cleared. Writes are injected during processing and during the result phase, and reads are injected outside the result phase. These separate true dropping of a byte from a byte that is silently stored or counted.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

  typedef enum logic [2:0] {
    PH_CMD    = 3'd0,
    PH_PROC   = 3'd1,
    PH_PARAM  = 3'd2,
    PH_EXEC   = 3'd3,
    PH_RESULT = 3'd4
  } phase_t;

  typedef struct packed {
    logic       legal;
    logic [3:0] count;
  } op_info_t;

  // opcode lookup on the five low bits; upper bits are modifiers
  function automatic op_info_t lookup_op(input logic [4:0] code);
    op_info_t info;
    info = '{legal: 1'b1, count: 4'd0};
    case (code)
      5'h03: info.count = 4'd2;
      5'h04: info.count = 4'd1;
      5'h05: info.count = 4'd8;
      5'h06: info.count = 4'd8;
      5'h07: info.count = 4'd1;
      5'h08: info.count = 4'd0;
      5'h0F: info.count = 4'd2;
      5'h13: info.count = 4'd3;
      default: info.legal = 1'b0;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/cmd_seq_decode.sv
module cmd_seq_decode
  import cmd_seq_pkg::*;
#(
  parameter int MAX_PARAMS = 8,
  localparam int CNT_W = $clog2(MAX_PARAMS + 1)
) (
  input  logic [4:0]       code,
  output logic [CNT_W-1:0] count,
  output logic             illegal
);

  op_info_t info;

  always_comb begin
    info    = lookup_op(code);
    count   = CNT_W'(info.count);
    illegal = !info.legal || (int'(info.count) > MAX_PARAMS);
  end

endmodule

// File: rtl/cmd_seq_pstore.sv
module cmd_seq_pstore #(
  parameter int DATA_W     = 8,
  parameter int MAX_PARAMS = 8,
  localparam int CNT_W = $clog2(MAX_PARAMS + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         we,
  input  logic [CNT_W-1:0]             idx,
  input  logic [DATA_W-1:0]            din,
  output logic [MAX_PARAMS*DATA_W-1:0] flat
);

  logic [DATA_W-1:0] slot [MAX_PARAMS];

  for (genvar g = 0; g < MAX_PARAMS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        slot[g] <= '0;
      end else if (we && idx == CNT_W'(g)) begin
        slot[g] <= din;
      end
    end
    assign flat[g*DATA_W +: DATA_W] = slot[g];
  end

endmodule

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
  import cmd_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MAX_PARAMS = 8,
  parameter int PROC_LAT   = 2,
  parameter logic [DATA_W-1:0] BAD_CODE = 8'h80,
  localparam int CNT_W = $clog2(MAX_PARAMS + 1),
  localparam int LAT_W = (PROC_LAT > 1) ? $clog2(PROC_LAT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              exec_done,
  input  logic [CNT_W-1:0]  need,
  input  logic              bad_op,
  output logic [DATA_W-1:0] opcode_q,
  output logic              store_clr,
  output logic              store_we,
  output logic [CNT_W-1:0]  store_idx,
  output logic              rqm_q,
  output logic              dio_q,
  output logic              busy_q,
  output logic              start_q,
  output logic              fifo_q,
  output logic              ovr_q,
  output logic [DATA_W-1:0] result_q
);

  phase_t            phase;
  logic [LAT_W-1:0]  lat_cnt;
  logic [CNT_W-1:0]  got;
  logic              wr_ok;
  logic              wr_take;

  assign wr_ok     = rqm_q && !dio_q;
  assign wr_take   = host_wr && wr_ok;
  assign store_clr = wr_take && (phase == PH_CMD);
  assign store_we  = wr_take && (phase == PH_PARAM);
  assign store_idx = got;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CMD;
      lat_cnt  <= '0;
      got      <= '0;
      opcode_q <= '0;
      rqm_q    <= 1'b1;
      dio_q    <= 1'b0;
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      fifo_q   <= 1'b0;
      ovr_q    <= 1'b0;
      result_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (host_wr && !wr_ok) begin
        ovr_q <= 1'b1;
      end
      case (phase)
        PH_CMD: begin
          if (wr_take) begin
            opcode_q <= host_wdata;
            got      <= '0;
            rqm_q    <= 1'b0;
            busy_q   <= 1'b1;
            lat_cnt  <= LAT_W'(PROC_LAT - 1);
            phase    <= PH_PROC;
          end
        end
        PH_PARAM: begin
          if (wr_take) begin
            got     <= got + 1'b1;
            rqm_q   <= 1'b0;
            lat_cnt <= LAT_W'(PROC_LAT - 1);
            phase   <= PH_PROC;
          end
        end
        PH_PROC: begin
          if (lat_cnt != '0) begin
            lat_cnt <= lat_cnt - 1'b1;
          end else if (bad_op) begin
            phase    <= PH_RESULT;
            rqm_q    <= 1'b1;
            dio_q    <= 1'b1;
            result_q <= BAD_CODE;
          end else if (got == need) begin
            phase   <= PH_EXEC;
            start_q <= 1'b1;
            fifo_q  <= 1'b1;
          end else begin
            phase <= PH_PARAM;
            rqm_q <= 1'b1;
          end
        end
        PH_EXEC: begin
          if (exec_done) begin
            phase  <= PH_CMD;
            rqm_q  <= 1'b1;
            busy_q <= 1'b0;
            fifo_q <= 1'b0;
          end
        end
        PH_RESULT: begin
          if (host_rd) begin
            phase    <= PH_CMD;
            rqm_q    <= 1'b1;
            dio_q    <= 1'b0;
            busy_q   <= 1'b0;
            result_q <= '0;
          end
        end
        default: phase <= PH_CMD;
      endcase
    end
  end

endmodule

// File: rtl/cmd_seq_top.sv
module cmd_seq_top #(
  parameter int DATA_W     = 8,
  parameter int MAX_PARAMS = 8,
  parameter int PROC_LAT   = 2,
  localparam int CNT_W = $clog2(MAX_PARAMS + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         host_wr,
  input  logic                         host_rd,
  input  logic [DATA_W-1:0]            host_wdata,
  output logic [DATA_W-1:0]            host_rdata,
  output logic [7:0]                   status,
  output logic                         exec_start,
  output logic [DATA_W-1:0]            exec_opcode,
  output logic [CNT_W-1:0]             exec_count,
  output logic [MAX_PARAMS*DATA_W-1:0] exec_params,
  input  logic                         exec_done,
  output logic                         fifo_en,
  output logic                         overrun
);

  logic [CNT_W-1:0] need;
  logic             bad_op;
  logic             store_clr;
  logic             store_we;
  logic [CNT_W-1:0] store_idx;
  logic             rqm_q;
  logic             dio_q;
  logic             busy_q;

  cmd_seq_ctrl #(
    .DATA_W(DATA_W), .MAX_PARAMS(MAX_PARAMS), .PROC_LAT(PROC_LAT)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .exec_done(exec_done), .need(need), .bad_op(bad_op),
    .opcode_q(exec_opcode),
    .store_clr(store_clr), .store_we(store_we), .store_idx(store_idx),
    .rqm_q(rqm_q), .dio_q(dio_q), .busy_q(busy_q),
    .start_q(exec_start), .fifo_q(fifo_en), .ovr_q(overrun),
    .result_q(host_rdata)
  );

  cmd_seq_decode #(.MAX_PARAMS(MAX_PARAMS)) dec_i (
    .code(exec_opcode[4:0]), .count(need), .illegal(bad_op)
  );

  cmd_seq_pstore #(.DATA_W(DATA_W), .MAX_PARAMS(MAX_PARAMS)) store_i (
    .clk(clk), .rst(rst), .clr(store_clr), .we(store_we),
    .idx(store_idx), .din(host_wdata), .flat(exec_params)
  );

  assign exec_count = need;
  assign status     = {rqm_q, dio_q, 1'b0, busy_q, 4'b0000};

endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic [7:0]        status,
  input logic [DATA_W-1:0] host_rdata,
  input logic              exec_start,
  input logic              fifo_en,
  input logic              overrun
);

  logic took;
  assign took = !rst && host_wr && status[7] && !status[6];

  assert_rqm_drop_R2: assert property (@(posedge clk) disable iff (rst)
    took |=> !status[7]);

  assert_rqm_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $past(took, 2) |-> !status[7]);

  assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> !exec_start);

  assert_start_fifo_R6: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> (fifo_en && !status[7]));

  assert_fifo_off_R6: assert property (@(posedge clk) disable iff (rst)
    status[7] |-> !fifo_en);

  assert_result_byte_R8: assert property (@(posedge clk) disable iff (rst)
    status[6] |-> (status[7] && host_rdata == DATA_W'(8'h80)));

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

endmodule

bind cmd_seq_top cmd_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .host_wr(host_wr), .status(status),
  .host_rdata(host_rdata), .exec_start(exec_start),
  .fifo_en(fifo_en), .overrun(overrun)
);

// File: tb/cmd_seq_top_tb_top.sv
module cmd_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [7:0]  status;
  logic        exec_start;
  logic [7:0]  exec_opcode;
  logic [3:0]  exec_count;
  logic [63:0] exec_params;
  logic        exec_done = 1'b0;
  logic        fifo_en;
  logic        overrun;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmd_seq_top dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .status(status),
    .exec_start(exec_start), .exec_opcode(exec_opcode),
    .exec_count(exec_count), .exec_params(exec_params),
    .exec_done(exec_done), .fifo_en(fifo_en), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // one-cycle write; returns at the negedge after the sampling edge
  task automatic wr(input logic [7:0] b);
    @(negedge clk); host_wr = 1'b1; host_wdata = b;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic finish_exec();
    @(negedge clk); exec_done = 1'b1;
    @(negedge clk); exec_done = 1'b0;
    chk("R7 status after done", 64'(status), 64'h80);
    chk("R7 fifo after done", 64'(fifo_en), 64'h0);
  endtask

  // send an opcode and its parameters, checking each handshake step
  task automatic send_cmd(input logic [7:0] op, input int n, input logic [63:0] prm);
    wr(op);
    chk("R2 busy cycle 1", 64'(status), 64'h10);
    @(negedge clk);
    chk("R2 busy cycle 2", 64'(status), 64'h10);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R4 ready for param", 64'(status), 64'h90);
      chk("R6 fifo off in command", 64'(fifo_en), 64'h0);
      wr(prm[k*8 +: 8]);
      chk("R2 param busy", 64'(status), 64'h10);
      @(negedge clk);
    end
    @(negedge clk);
    chk("R5 start pulse", 64'(exec_start), 64'h1);
    chk("R5 ready stays 0", 64'(status), 64'h10);
    chk("R5 opcode", 64'(exec_opcode), 64'(op));
    chk("R3 count", 64'(exec_count), 64'(n));
    chk("R5 params", exec_params, prm);
    chk("R6 fifo on", 64'(fifo_en), 64'h1);
    @(negedge clk);
    chk("R5 pulse single", 64'(exec_start), 64'h0);
    chk("R6 fifo held", 64'(fifo_en), 64'h1);
  endtask

  task automatic t_reset();
    chk("R1 status", 64'(status), 64'h80);
    chk("R1 start", 64'(exec_start), 64'h0);
    chk("R1 fifo", 64'(fifo_en), 64'h0);
    chk("R1 overrun", 64'(overrun), 64'h0);
    chk("R1 rdata", 64'(host_rdata), 64'h0);
  endtask

  task automatic t_two_params();
    send_cmd(8'h03, 2, 64'h12AB);
    finish_exec();
  endtask

  task automatic t_long_then_short();
    logic [63:0] p;
    for (int k = 0; k < 8; k++) p[k*8 +: 8] = 8'h40 + 8'(k);
    send_cmd(8'hE6, 8, p);          // R3 upper bits masked
    finish_exec();
    send_cmd(8'h08, 0, 64'h0);      // R5 stale slots cleared
    finish_exec();
    send_cmd(8'h33, 3, 64'h0C0B0A); // R3 0x33 -> 0x13
    finish_exec();
    send_cmd(8'h07, 1, 64'h5A);
    finish_exec();
  endtask

  task automatic t_illegal();
    wr(8'h1F);
    @(negedge clk);
    @(negedge clk);
    chk("R8 status result", 64'(status), 64'hD0);
    chk("R8 rdata", 64'(host_rdata), 64'h80);
    chk("R8 no start", 64'(exec_start), 64'h0);
    chk("R6 fifo off in result", 64'(fifo_en), 64'h0);
    wr(8'h55);
    chk("R10 write in result dropped", 64'(status), 64'hD0);
    chk("R10 overrun set", 64'(overrun), 64'h1);
    rd_pulse();
    chk("R9 status back", 64'(status), 64'h80);
    chk("R9 rdata cleared", 64'(host_rdata), 64'h0);
    chk("R10 overrun sticky", 64'(overrun), 64'h1);
  endtask

  task automatic t_overrun_collect();
    do_reset();
    chk("R1 overrun cleared", 64'(overrun), 64'h0);
    wr(8'h0F);
    @(negedge clk); @(negedge clk);
    wr(8'h21);
    wr(8'hEE);                       // arrives while ready is 0
    chk("R10 overrun on busy write", 64'(overrun), 64'h1);
    @(negedge clk);
    chk("R10 count not advanced", 64'(status), 64'h90);
    wr(8'h22);
    @(negedge clk); @(negedge clk);
    chk("R10 start after real param", 64'(exec_start), 64'h1);
    chk("R10 params exclude dropped", exec_params, 64'h2221);
    finish_exec();
  endtask

  task automatic t_stray_read();
    rd_pulse();
    chk("R11 status idle", 64'(status), 64'h80);
    chk("R11 rdata idle", 64'(host_rdata), 64'h0);
    wr(8'h04);
    @(negedge clk); @(negedge clk);
    rd_pulse();
    chk("R11 status in param wait", 64'(status), 64'h90);
    wr(8'h77);
    @(negedge clk); @(negedge clk);
    chk("R11 start", 64'(exec_start), 64'h1);
    chk("R11 params", exec_params, 64'h77);
    finish_exec();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_two_params();
    t_long_then_short();
    t_illegal();
    t_overrun_collect();
    t_stray_read();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule